// File: doc/BRIEF.md
# Dual-Channel Result Readout Port

This block sits between a two-channel conversion sequencer and a parallel host bus. It keeps one result register per channel and presents one of them on a registered output word. A separate output-enable tells the pad ring when to drive the pins and when to float them. The bus is driven only while the host holds both its active-low chip-select and its active-low read strobe. A channel-select input picks which channel's register is shown. A byte-swap input exchanges the two byte lanes, so a host with an 8-bit data path can fetch both bytes of a result from whichever half of the bus it is wired to.

Channel A is always converted first. Its register takes the new result as soon as the sequencer raises the channel-A-done flag, so the host can read channel A while channel B is still in progress. Channel B's register loads only when the busy flag drops, and until then a read of channel B returns the earlier result. Results are straight binary codes and pass through the port unaltered. A host that ties chip-select and read low permanently gets a bus that is driven continuously and follows each new result.

Top module: `dual_result_port`

## Requirements
- R1: While `rst_n` is low, and after reset until a read is requested, `bus_drive_o` is 0. Whenever `bus_drive_o` is 0, `bus_data_o` is all zeros. Both result registers clear to 0x0000 on reset.
- R2: `bus_drive_o` is 1 at the clock edge after an edge at which `cs_n_i` and `rd_n_i` were both sampled low. It is 0 at the edge after either of them was sampled high.
- R3: While driving with `sel_a_i`=1, the bus carries the channel A register. With `sel_a_i`=0 it carries the channel B register.
- R4: With `swap_i`=0, bits 7..0 carry result bits 7..0 and bits 15..8 carry result bits 15..8. With `swap_i`=1, bits 7..0 carry result bits 15..8 and bits 15..8 carry result bits 7..0.
- R5: At the first edge that samples `a_done_i` high after it was low, the channel A register loads `res_a_i`. The new value can be read one edge later, even while `busy_i` is still 1.
- R6: The channel B register loads `res_b_i` only at the edge that samples `busy_i` low after it was high. Before that, reads of channel B return the previous result.
- R7: A change on `sel_a_i` or `swap_i` appears on `bus_data_o` at the next clock edge.
- R8: With `cs_n_i` and `rd_n_i` held low across whole conversions, `bus_drive_o` stays 1 and the bus follows each newly latched result.
- R9: Codes are passed unchanged over the full straight-binary range. 0x0000 and 0xFFFF read back exactly, as do arbitrary codes in between.
- R10: Outside its load event, each result register holds its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| res_a_i | input | 16 | Channel A conversion result from the sequencer |
| res_b_i | input | 16 | Channel B conversion result from the sequencer |
| a_done_i | input | 1 | High once channel A has finished converting |
| busy_i | input | 1 | High while a conversion (A then B) is in progress |
| cs_n_i | input | 1 | Active-low chip-select |
| rd_n_i | input | 1 | Active-low read strobe |
| sel_a_i | input | 1 | 1 selects channel A, 0 selects channel B |
| swap_i | input | 1 | 1 exchanges the two byte lanes |
| bus_data_o | output | 16 | Registered output word, zero when not driving |
| bus_drive_o | output | 1 | Pad output-enable: 1 drives the bus, 0 floats it |

## Verification
The bench uses the default build: a 16-bit result split into two 8-bit lanes. With only two lanes and two select bits, every combination of channel and swap can be read back after each conversion. The result patterns cover both ends of the code range, walking single bits in each byte, and mixed codes. Together these expose any crossed lane, stuck bit or wrongly timed load. Each conversion is stepped one edge at a time, so the reads in the window between channel A finishing and busy falling show the early channel A value next to the stale channel B value.

// File: rtl/dual_result_port_pkg.sv
// Package: shared types for the dual-channel readout port.
// Assumes: channel selection is a single bit, 1 meaning channel A.
package dual_result_port_pkg;

    typedef enum logic {
        CHAN_B = 1'b0,
        CHAN_A = 1'b1
    } chan_sel_e;

    typedef enum logic {
        EDGE_RISE = 1'b0,
        EDGE_FALL = 1'b1
    } edge_kind_e;

endpackage

// File: rtl/port_edge_det.sv
// Module: single-cycle edge detector on a level flag.
// Assumes: the input is synchronous to clk. The delay flop clears on reset,
// so a flag that is already high when reset ends is not reported as a fall.
module port_edge_det
    import dual_result_port_pkg::*;
#(
    parameter edge_kind_e KIND = EDGE_RISE
) (
    input  logic clk,
    input  logic rst_n,
    input  logic level_i,
    output logic hit_o
);

    logic level_d;

    // Keep the previous sample of the flag.
    always_ff @(posedge clk) begin
        if (!rst_n) level_d <= 1'b0;
        else        level_d <= level_i;
    end

    generate
        if (KIND == EDGE_RISE) begin : g_rise
            // Report a low-to-high change.
            assign hit_o = level_i & ~level_d;
        end else begin : g_fall
            // Report a high-to-low change.
            assign hit_o = ~level_i & level_d;
        end
    endgenerate

endmodule

// File: rtl/port_result_hold.sv
// Module: result register that loads on a one-cycle strobe and holds otherwise.
// Assumes: the strobe lines up with the cycle in which the data is valid.
module port_result_hold #(
    parameter int unsigned WIDTH = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [WIDTH-1:0] data_i,
    output logic [WIDTH-1:0] hold_o
);

    // Capture on strobe, clear on reset.
    always_ff @(posedge clk) begin
        if (!rst_n)      hold_o <= '0;
        else if (load_i) hold_o <= data_i;
    end

endmodule

// File: rtl/port_lane_swap.sv
// Module: reverses the order of byte lanes when swap is set.
// Assumes: WIDTH is a whole multiple of LANE_W. With two lanes this exchanges
// the high and low halves.
module port_lane_swap #(
    parameter int unsigned WIDTH  = 16,
    parameter int unsigned LANE_W = 8
) (
    input  logic             swap_i,
    input  logic [WIDTH-1:0] word_i,
    output logic [WIDTH-1:0] word_o
);

    localparam int unsigned NUM_LANES = WIDTH / LANE_W;

    generate
        for (genvar i = 0; i < NUM_LANES; i++) begin : g_lane
            localparam int unsigned SRC = NUM_LANES - 1 - i;
            // Pick the straight or mirrored lane for position i.
            assign word_o[i*LANE_W +: LANE_W] =
                swap_i ? word_i[SRC*LANE_W +: LANE_W] : word_i[i*LANE_W +: LANE_W];
        end
    endgenerate

endmodule

// File: rtl/dual_result_port.sv
// Module: dual-channel result readout onto a registered parallel bus.
// Channel A loads on the rise of the done flag and channel B on the fall of
// busy, so channel A can be read early. The output word and the pad enable are
// both registered. Assumes all inputs are synchronous to clk and that the pad
// ring applies bus_drive_o as the tri-state enable.
module dual_result_port
    import dual_result_port_pkg::*;
#(
    parameter int unsigned DATA_W = 16,
    parameter int unsigned LANE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] res_a_i,
    input  logic [DATA_W-1:0] res_b_i,
    input  logic              a_done_i,
    input  logic              busy_i,
    input  logic              cs_n_i,
    input  logic              rd_n_i,
    input  logic              sel_a_i,
    input  logic              swap_i,
    output logic [DATA_W-1:0] bus_data_o,
    output logic              bus_drive_o
);

    logic              a_load;
    logic              b_load;
    logic [DATA_W-1:0] hold_a;
    logic [DATA_W-1:0] hold_b;
    logic [DATA_W-1:0] chosen;
    logic [DATA_W-1:0] laned;
    logic              read_req;
    chan_sel_e         chan;

    port_edge_det #(.KIND(EDGE_RISE)) u_a_edge (
        .clk     (clk),
        .rst_n   (rst_n),
        .level_i (a_done_i),
        .hit_o   (a_load)
    );

    port_edge_det #(.KIND(EDGE_FALL)) u_b_edge (
        .clk     (clk),
        .rst_n   (rst_n),
        .level_i (busy_i),
        .hit_o   (b_load)
    );

    port_result_hold #(.WIDTH(DATA_W)) u_hold_a (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (a_load),
        .data_i (res_a_i),
        .hold_o (hold_a)
    );

    port_result_hold #(.WIDTH(DATA_W)) u_hold_b (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (b_load),
        .data_i (res_b_i),
        .hold_o (hold_b)
    );

    // Decode the channel choice and the read request.
    always_comb begin
        chan     = chan_sel_e'(sel_a_i);
        chosen   = (chan == CHAN_A) ? hold_a : hold_b;
        read_req = ~cs_n_i & ~rd_n_i;
    end

    port_lane_swap #(.WIDTH(DATA_W), .LANE_W(LANE_W)) u_swap (
        .swap_i (swap_i),
        .word_i (chosen),
        .word_o (laned)
    );

    // Register the pad enable and the output word; zero the word when floating.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bus_drive_o <= 1'b0;
            bus_data_o  <= '0;
        end else begin
            bus_drive_o <= read_req;
            bus_data_o  <= read_req ? laned : '0;
        end
    end

endmodule

// File: rtl/dual_result_port_chk.sv
// Module: assertion checker for dual_result_port, attached by bind.
// Assumes: the two result registers are reachable through the bind connection.
module dual_result_port_chk #(
    parameter int unsigned DATA_W = 16,
    parameter int unsigned LANE_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic [DATA_W-1:0] res_a_i,
    input logic [DATA_W-1:0] res_b_i,
    input logic              a_done_i,
    input logic              busy_i,
    input logic              cs_n_i,
    input logic              rd_n_i,
    input logic              sel_a_i,
    input logic              swap_i,
    input logic [DATA_W-1:0] bus_data_o,
    input logic              bus_drive_o,
    input logic [DATA_W-1:0] hold_a,
    input logic [DATA_W-1:0] hold_b
);

    localparam int unsigned HALF = DATA_W / 2;

    // R1: a floating bus carries zeros
    a_r1_quiet_when_floating: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_drive_o |-> (bus_data_o == '0));

    // R2: enable follows the strobes one edge later
    a_r2_drive_on_request: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_n_i && !rd_n_i) |=> bus_drive_o);

    a_r2_float_on_release: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_n_i || rd_n_i) |=> !bus_drive_o);

    // R3: straight read of the selected channel
    a_r3_channel_a: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_n_i && !rd_n_i && sel_a_i && !swap_i) |=> (bus_data_o == $past(hold_a)));

    a_r3_channel_b: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_n_i && !rd_n_i && !sel_a_i && !swap_i) |=> (bus_data_o == $past(hold_b)));

    // R4: swapped read exchanges the halves
    a_r4_swapped_b: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_n_i && !rd_n_i && !sel_a_i && swap_i) |=>
        (bus_data_o == {$past(hold_b[HALF-1:0]), $past(hold_b[DATA_W-1:HALF])}));

    // R5: channel A loads on the done rise
    a_r5_a_loads: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(a_done_i) && $past(rst_n)) |=> (hold_a == $past(res_a_i)));

    // R6: channel B loads on the busy fall
    a_r6_b_loads: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(busy_i) && $past(rst_n)) |=> (hold_b == $past(res_b_i)));

    // R10: registers hold outside their load events
    a_r10_a_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !($rose(a_done_i) && $past(rst_n)) |=> $stable(hold_a));

    a_r10_b_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !($fell(busy_i) && $past(rst_n)) |=> $stable(hold_b));

endmodule

bind dual_result_port dual_result_port_chk #(
    .DATA_W (DATA_W),
    .LANE_W (LANE_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .res_a_i     (res_a_i),
    .res_b_i     (res_b_i),
    .a_done_i    (a_done_i),
    .busy_i      (busy_i),
    .cs_n_i      (cs_n_i),
    .rd_n_i      (rd_n_i),
    .sel_a_i     (sel_a_i),
    .swap_i      (swap_i),
    .bus_data_o  (bus_data_o),
    .bus_drive_o (bus_drive_o),
    .hold_a      (hold_a),
    .hold_b      (hold_b)
);

// File: tb/tb_dual_result_port.sv
`timescale 1ns/1ps
module tb_dual_result_port;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [15:0] res_a, res_b;
    logic        a_done, busy, cs_n, rd_n, sel_a, swap;
    logic [15:0] bus_data;
    logic        bus_drive;

    int checks   = 0;
    int failures = 0;
    logic [15:0] exp_a = 16'h0000;
    logic [15:0] exp_b = 16'h0000;

    always #2.5 clk = ~clk;

    dual_result_port dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .res_a_i     (res_a),
        .res_b_i     (res_b),
        .a_done_i    (a_done),
        .busy_i      (busy),
        .cs_n_i      (cs_n),
        .rd_n_i      (rd_n),
        .sel_a_i     (sel_a),
        .swap_i      (swap),
        .bus_data_o  (bus_data),
        .bus_drive_o (bus_drive)
    );

    // Advance one edge; inputs change and outputs are sampled 1 ns after it.
    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    function automatic logic [15:0] lanes(input logic [15:0] v, input logic sw);
        return sw ? {v[7:0], v[15:8]} : v;
    endfunction

    task automatic check(input string req, input logic [16:0] act, input logic [16:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Read every channel/swap combination: R3, R4, R7.
    task automatic read_all(input string req);
        for (int c = 0; c < 4; c++) begin
            sel_a = c[0];
            swap  = c[1];
            tick();
            check(req, {bus_drive, bus_data},
                  {1'b1, lanes(c[0] ? exp_a : exp_b, c[1])});
        end
    endtask

    // One conversion with reads in the gap after channel A finishes: R5, R6.
    task automatic convert(input logic [15:0] va, input logic [15:0] vb);
        res_a = va;
        res_b = vb;
        busy  = 1'b1;
        tick();
        a_done = 1'b1;
        tick();                 // channel A loads at this edge
        exp_a = va;
        sel_a = 1'b1; swap = 1'b0;
        tick();
        check("R5 early A", {bus_drive, bus_data}, {1'b1, va});
        sel_a = 1'b0;
        tick();
        check("R6 stale B", {bus_drive, bus_data}, {1'b1, exp_b});
        busy   = 1'b0;
        a_done = 1'b0;
        tick();                 // channel B loads at this edge
        exp_b = vb;
        tick();
        check("R6 new B", {bus_drive, bus_data}, {1'b1, vb});
        res_a = ~va;            // R10: input changes without an event
        res_b = ~vb;
        read_all("R3/R4/R9/R10 readback");
    endtask

    initial begin
        rst_n = 1'b0; res_a = 16'h0; res_b = 16'h0;
        a_done = 1'b0; busy = 1'b0; cs_n = 1'b0; rd_n = 1'b0;
        sel_a = 1'b1; swap = 1'b0;
        tick(); tick();
        check("R1 drive in reset", {16'h0, bus_drive}, 17'h0);
        check("R1 data in reset", {1'b0, bus_data}, 17'h0);
        cs_n = 1'b1;
        rst_n = 1'b1;
        tick();
        check("R1 idle after reset", {bus_drive, bus_data}, 17'h0);
        cs_n = 1'b0;
        tick();
        check("R1 cleared A", {bus_drive, bus_data}, {1'b1, 16'h0});

        // R9: extremes and mixed codes, with walking bits in each byte.
        convert(16'h0000, 16'hFFFF);
        convert(16'hFFFF, 16'h0000);
        convert(16'h1234, 16'hABCD);
        for (int i = 0; i < 16; i++)
            convert(16'h1 << i, 16'h8000 >> i);

        // R2: either strobe high floats the bus, both low drives it.
        sel_a = 1'b1; swap = 1'b0;
        cs_n = 1'b1; tick();
        check("R2 cs high", {bus_drive, bus_data}, 17'h0);
        cs_n = 1'b0; rd_n = 1'b1; tick();
        check("R2 rd high", {bus_drive, bus_data}, 17'h0);
        rd_n = 1'b0; tick();
        check("R2 both low", {bus_drive, bus_data}, {1'b1, exp_a});

        // R7: select and swap changes land one edge later.
        swap = 1'b1; tick();
        check("R7 swap", {bus_drive, bus_data}, {1'b1, lanes(exp_a, 1'b1)});
        sel_a = 1'b0; tick();
        check("R7 select", {bus_drive, bus_data}, {1'b1, lanes(exp_b, 1'b1)});

        // R8: strobes held low through a conversion keep the bus driven.
        sel_a = 1'b1; swap = 1'b0;
        res_a = 16'h5A5A; res_b = 16'hC3C3; busy = 1'b1;
        for (int k = 0; k < 6; k++) begin
            if (k == 1) a_done = 1'b1;
            if (k == 4) begin busy = 1'b0; a_done = 1'b0; end
            tick();
            check("R8 continuous drive", {16'h0, bus_drive}, 17'h1);
        end
        check("R8 follows A", {1'b0, bus_data}, {1'b0, 16'h5A5A});
        sel_a = 1'b0; tick();
        check("R8 follows B", {1'b0, bus_data}, {1'b0, 16'hC3C3});

        // R1: asserting reset floats the bus and clears both results.
        rst_n = 1'b0; tick();
        check("R1 reset floats", {bus_drive, bus_data}, 17'h0);
        rst_n = 1'b1; tick(); tick();
        check("R1 B cleared", {bus_drive, bus_data}, {1'b1, 16'h0});

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule